// File: doc/BRIEF.md
# Packet Slab-Tree Traversal Step Unit

This block advances a packet of rays by one step through a binary spatial tree. In that tree, every inner node holds two one-dimensional child slabs, each a [low, high] bound pair, along one coordinate axis. Each ray keeps its own traversal interval [near, far], a closest-hit distance and an active bit. Every ray also supplies a fixed-point origin and inverse direction for each of the three axes. The caller holds these two vectors steady at the ports for the whole walk.

On each cycle with a node presented, the unit does the following for all rays of the packet in lockstep:
- It turns the four slab bounds into two entry/exit intervals per ray.
- It drops rays whose hit already lies before their near distance.
- It decides which children the packet must visit and in which order.
- It clips the intervals and either descends, descends and defers the second child onto a per-packet stack, or pops the stack.

The address to fetch next appears on `fetch_addr`. When no child is needed and the stack is empty, the walk is finished.

The controller has three named states. ST_IDLE is the state after reset. ST_WALK is entered from ST_IDLE or ST_DONE on `start`, and a `start` in ST_WALK restarts it. ST_DONE is entered from ST_WALK when a step needs no child and finds the stack empty.

Top module: `slab_step_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE with `busy`=0, `done`=0, `stack_overflow`=0 and `act_mask`=0.
- R2: `start` loads `root_addr` into `fetch_addr`, `ray_valid` into `act_mask`, and the initial near, far and hit values per ray. It empties the stack and enters ST_WALK (`busy`=1, `done`=0) at the next edge.
- R3: The plane distance of a bound b for a ray is ((b − origin) × invdir) >>> FRAC, truncated to DW bits, signed. It uses the origin and inverse-direction component selected by `node_axis` (0 picks component 0, 1 picks component 1, 2 and 3 pick component 2). A child's entry is the smaller and its exit the larger of the distances of its low and high bounds.
- R4: A ray needs a child only when it is active, is not terminated, and satisfies entry ≤ far and exit ≥ near, all compared as signed values.
- R5: A ray whose stored hit is strictly less than its near distance at a step is terminated. It needs no child, and it votes for neither child.
- R6: When exactly one child is needed, the unit descends to it. `act_mask` becomes the set of rays needing it, and each such ray gets near = max(near, entry) and far = min(far, exit).
- R7: When both children are needed, the packet goes first to the child preferred by more rays. A ray prefers the child with the smaller entry (child 0 on equal entries), or the only child it needs. Equal vote counts pick child 0. The other child's address, its mask of needing rays and their clipped intervals are pushed onto the stack.
- R8: When no child is needed, the top stack entry restores `fetch_addr`, `act_mask` and the intervals. With the stack empty, the unit enters ST_DONE (`done`=1, `busy`=0) and `fetch_addr` holds its value.
- R9: One step is taken per clock edge in ST_WALK where `node_valid` is high. With `node_valid` low, `fetch_addr`, `act_mask` and the intervals hold.
- R10: The stack holds DEPTH entries. A push when full is dropped and sets `stack_overflow`, which stays set until the next `start`. The descent itself still happens.
- R11: `hit_we[i]` writes `hit_data[i]` as ray i's hit distance at the edge. The new value is used from the next step on.
- R12: A `start` in ST_DONE clears `stack_overflow` and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new packet and begin a walk |
| ray_valid | input | NR | Initial active mask |
| root_addr | input | AW | First node address |
| init_near | input | NR×DW | Initial near distance per ray |
| init_far | input | NR×DW | Initial far distance per ray |
| init_hit | input | NR×DW | Initial hit distance per ray |
| ray_org | input | NR×3×DW | Per-ray per-axis origin, fixed point |
| ray_inv | input | NR×3×DW | Per-ray per-axis inverse direction, FRAC fraction bits |
| hit_we | input | NR | Per-ray hit-distance write enable |
| hit_data | input | NR×DW | New hit distances |
| node_valid | input | 1 | A node is presented this cycle |
| node_axis | input | 2 | Axis of the node's slabs |
| node_lo0 | input | DW | Child 0 low bound |
| node_hi0 | input | DW | Child 0 high bound |
| node_lo1 | input | DW | Child 1 low bound |
| node_hi1 | input | DW | Child 1 high bound |
| node_child0 | input | AW | Child 0 address |
| node_child1 | input | AW | Child 1 address |
| fetch_addr | output | AW | Node to present next |
| act_mask | output | NR | Rays taking part in the current subtree |
| cur_near | output | NR×DW | Current near per ray |
| cur_far | output | NR×DW | Current far per ray |
| busy | output | 1 | In ST_WALK |
| done | output | 1 | In ST_DONE |
| stack_overflow | output | 1 | A push was dropped since the last start |

## Verification
The bench builds the unit with NR=4, DW=16, FRAC=4, AW=8 and DEPTH=4. With FRAC=4, inverse directions of 16, −16 and 32 give exact plane distances of 1, −1 and 2 times the bound offset. This makes every entry, exit and clipped interval easy to state as a plain integer. The shallow stack lets a run of five double-overlap nodes overflow it. The following pops then show that the dropped entry never returns and that the walk still finishes.

// File: rtl/slab_pkg.sv
package slab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;
endpackage

// File: rtl/slab_ray_eval.sv
module slab_ray_eval #(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 act,
    input  logic [1:0]           axis,
    input  logic [DW-1:0]        near,
    input  logic [DW-1:0]        far,
    input  logic [DW-1:0]        hit,
    input  logic [2:0][DW-1:0]   org,
    input  logic [2:0][DW-1:0]   inv,
    input  logic [DW-1:0]        lo0,
    input  logic [DW-1:0]        hi0,
    input  logic [DW-1:0]        lo1,
    input  logic [DW-1:0]        hi1,
    output logic                 ov0,
    output logic                 ov1,
    output logic                 pref1,
    output logic [DW-1:0]        cn0,
    output logic [DW-1:0]        cf0,
    output logic [DW-1:0]        cn1,
    output logic [DW-1:0]        cf1
);
    function automatic logic signed [DW-1:0] plane_dist(
        input logic signed [DW-1:0] b,
        input logic signed [DW-1:0] o,
        input logic signed [DW-1:0] v
    );
        logic signed [DW:0]   d;
        logic signed [2*DW:0] p;
        d = {b[DW-1], b} - {o[DW-1], o};
        p = d * v;
        return DW'(p >>> FRAC);
    endfunction

    logic signed [DW-1:0] o_s, v_s, nr, fr, ta0, tb0, ta1, tb1;
    logic signed [DW-1:0] en0, ex0, en1, ex1;
    logic                 live;

    always_comb begin
        o_s  = $signed(org[(axis == 2'd0) ? 0 : (axis == 2'd1) ? 1 : 2]);
        v_s  = $signed(inv[(axis == 2'd0) ? 0 : (axis == 2'd1) ? 1 : 2]);
        nr   = $signed(near);
        fr   = $signed(far);
        ta0  = plane_dist($signed(lo0), o_s, v_s);
        tb0  = plane_dist($signed(hi0), o_s, v_s);
        ta1  = plane_dist($signed(lo1), o_s, v_s);
        tb1  = plane_dist($signed(hi1), o_s, v_s);
        en0  = (ta0 < tb0) ? ta0 : tb0;
        ex0  = (ta0 < tb0) ? tb0 : ta0;
        en1  = (ta1 < tb1) ? ta1 : tb1;
        ex1  = (ta1 < tb1) ? tb1 : ta1;
        live = act && !($signed(hit) < nr);
        ov0  = live && (en0 <= fr) && (ex0 >= nr);
        ov1  = live && (en1 <= fr) && (ex1 >= nr);
        pref1 = ov1 && (!ov0 || (en1 < en0));
        cn0  = (nr > en0) ? nr : en0;
        cf0  = (fr < ex0) ? fr : ex0;
        cn1  = (nr > en1) ? nr : en1;
        cf1  = (fr < ex1) ? fr : ex1;
    end
endmodule

// File: rtl/slab_vote.sv
module slab_vote #(
    parameter int NR = 4
) (
    input  logic [NR-1:0] ov0,
    input  logic [NR-1:0] ov1,
    input  logic [NR-1:0] pref1,
    output logic          need0,
    output logic          need1,
    output logic          first1
);
    logic [NR-1:0] pref0;

    always_comb begin
        pref0  = (ov0 | ov1) & ~pref1;
        need0  = |ov0;
        need1  = |ov1;
        first1 = need1 && (!need0 || ($countones(pref1) > $countones(pref0)));
    end
endmodule

// File: rtl/slab_stack.sv
module slab_stack #(
    parameter int NR    = 4,
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic                    pop,
    input  logic [AW-1:0]           push_addr,
    input  logic [NR-1:0]           push_mask,
    input  logic [NR-1:0][DW-1:0]   push_near,
    input  logic [NR-1:0][DW-1:0]   push_far,
    output logic [AW-1:0]           top_addr,
    output logic [NR-1:0]           top_mask,
    output logic [NR-1:0][DW-1:0]   top_near,
    output logic [NR-1:0][DW-1:0]   top_far,
    output logic                    empty,
    output logic                    overflow
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]         addr_m [DEPTH];
    logic [NR-1:0]         mask_m [DEPTH];
    logic [NR-1:0][DW-1:0] near_m [DEPTH];
    logic [NR-1:0][DW-1:0] far_m  [DEPTH];
    logic [CW-1:0]         cnt_q;
    logic                  ovf_q, full;
    logic [IW-1:0]         wr_idx, rd_idx;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign overflow = ovf_q;
    assign wr_idx   = IW'(cnt_q);
    assign rd_idx   = IW'(cnt_q - CW'(1));
    assign top_addr = addr_m[rd_idx];
    assign top_mask = mask_m[rd_idx];
    assign top_near = near_m[rd_idx];
    assign top_far  = far_m[rd_idx];

    always_ff @(posedge clk) begin
        if (push && !full && !clr) begin
            addr_m[wr_idx] <= push_addr;
            mask_m[wr_idx] <= push_mask;
            near_m[wr_idx] <= push_near;
            far_m[wr_idx]  <= push_far;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (push) begin
            if (full) ovf_q <= 1'b1;
            else      cnt_q <= cnt_q + CW'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> (cnt_q == CW'(DEPTH)) && ovf_q);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);
    // R8
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/slab_step_unit.sv
module slab_step_unit
    import slab_pkg::*;
#(
    parameter int NR    = 4,
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int AW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NR-1:0]                ray_valid,
    input  logic [AW-1:0]                root_addr,
    input  logic [NR-1:0][DW-1:0]        init_near,
    input  logic [NR-1:0][DW-1:0]        init_far,
    input  logic [NR-1:0][DW-1:0]        init_hit,
    input  logic [NR-1:0][2:0][DW-1:0]   ray_org,
    input  logic [NR-1:0][2:0][DW-1:0]   ray_inv,
    input  logic [NR-1:0]                hit_we,
    input  logic [NR-1:0][DW-1:0]        hit_data,
    input  logic                         node_valid,
    input  logic [1:0]                   node_axis,
    input  logic [DW-1:0]                node_lo0,
    input  logic [DW-1:0]                node_hi0,
    input  logic [DW-1:0]                node_lo1,
    input  logic [DW-1:0]                node_hi1,
    input  logic [AW-1:0]                node_child0,
    input  logic [AW-1:0]                node_child1,
    output logic [AW-1:0]                fetch_addr,
    output logic [NR-1:0]                act_mask,
    output logic [NR-1:0][DW-1:0]        cur_near,
    output logic [NR-1:0][DW-1:0]        cur_far,
    output logic                         busy,
    output logic                         done,
    output logic                         stack_overflow
);
    walk_state_t state_q, state_d;

    logic [AW-1:0]         addr_q;
    logic [NR-1:0]         mask_q;
    logic [NR-1:0][DW-1:0] near_q, far_q, hit_q;

    logic [NR-1:0]         ov0_v, ov1_v, pref1_v;
    logic [NR-1:0][DW-1:0] cn0_v, cf0_v, cn1_v, cf1_v;
    logic                  need0, need1, first1;
    logic                  step, desc, push, pop, stk_empty;
    logic [AW-1:0]         top_addr;
    logic [NR-1:0]         top_mask;
    logic [NR-1:0][DW-1:0] top_near, top_far;

    for (genvar i = 0; i < NR; i++) begin : g_ray
        slab_ray_eval #(.DW(DW), .FRAC(FRAC)) i_eval (
            .act  (mask_q[i]),
            .axis (node_axis),
            .near (near_q[i]),
            .far  (far_q[i]),
            .hit  (hit_q[i]),
            .org  (ray_org[i]),
            .inv  (ray_inv[i]),
            .lo0  (node_lo0),
            .hi0  (node_hi0),
            .lo1  (node_lo1),
            .hi1  (node_hi1),
            .ov0  (ov0_v[i]),
            .ov1  (ov1_v[i]),
            .pref1(pref1_v[i]),
            .cn0  (cn0_v[i]),
            .cf0  (cf0_v[i]),
            .cn1  (cn1_v[i]),
            .cf1  (cf1_v[i])
        );
    end

    slab_vote #(.NR(NR)) i_vote (
        .ov0   (ov0_v),
        .ov1   (ov1_v),
        .pref1 (pref1_v),
        .need0 (need0),
        .need1 (need1),
        .first1(first1)
    );

    assign step = (state_q == ST_WALK) && node_valid && !start;
    assign desc = step && (need0 || need1);
    assign push = step && need0 && need1;
    assign pop  = step && !need0 && !need1 && !stk_empty;

    slab_stack #(.NR(NR), .DW(DW), .AW(AW), .DEPTH(DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .push     (push),
        .pop      (pop),
        .push_addr(first1 ? node_child0 : node_child1),
        .push_mask(first1 ? ov0_v : ov1_v),
        .push_near(first1 ? cn0_v : cn1_v),
        .push_far (first1 ? cf0_v : cf1_v),
        .top_addr (top_addr),
        .top_mask (top_mask),
        .top_near (top_near),
        .top_far  (top_far),
        .empty    (stk_empty),
        .overflow (stack_overflow)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WALK;
            ST_WALK: if (step && !need0 && !need1 && stk_empty) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_WALK;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = (state_q == ST_WALK);
        done       = (state_q == ST_DONE);
        fetch_addr = addr_q;
        act_mask   = mask_q;
        cur_near   = near_q;
        cur_far    = far_q;
    end

    // Packet datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            near_q <= '0;
            far_q  <= '0;
            hit_q  <= '0;
        end else if (start) begin
            addr_q <= root_addr;
            mask_q <= ray_valid;
            near_q <= init_near;
            far_q  <= init_far;
            hit_q  <= init_hit;
        end else begin
            for (int i = 0; i < NR; i++)
                if (hit_we[i]) hit_q[i] <= hit_data[i];
            if (desc) begin
                addr_q <= first1 ? node_child1 : node_child0;
                mask_q <= first1 ? ov1_v : ov0_v;
                near_q <= first1 ? cn1_v : cn0_v;
                far_q  <= first1 ? cf1_v : cf0_v;
            end else if (pop) begin
                addr_q <= top_addr;
                mask_q <= top_mask;
                near_q <= top_near;
                far_q  <= top_far;
            end
        end
    end

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> stk_empty);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WALK) && !node_valid && !start) |=> $stable(fetch_addr) && $stable(act_mask));
    // R6
    mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc |=> ((act_mask & ~$past(act_mask)) == '0));

    for (genvar i = 0; i < NR; i++) begin : g_ivl_chk
        // R6
        ivl_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (desc && (first1 ? ov1_v[i] : ov0_v[i])) |=> ($signed(cur_near[i]) <= $signed(cur_far[i])));
    end
endmodule

// File: tb/test_slab_step_unit.sv
module test_slab_step_unit;
    localparam int NR = 4, DW = 16, FRAC = 4, AW = 8, DEPTH = 4;

    typedef struct packed {
        logic [1:0]  axis;
        logic [15:0] lo0, hi0, lo1, hi1;
        logic [7:0]  c0, c1, eaddr;
        logic [3:0]  emask;
        logic [15:0] na, fa, nb, fb;
        logic        edone;
    } vec_t;

    // Rays 0,1 have origin 0 on axis 0; rays 2,3 have origin 10. Expected na/fa for rays 0,1; nb/fb for rays 2,3.
    localparam vec_t TBL [8] = '{
        '{2'd0, 16'sd20, 16'sd40, 16'sd50, 16'sd70, 8'd2, 8'd3, 8'd2, 4'hF, 16'sd20, 16'sd40, 16'sd10, 16'sd30, 1'b0},
        '{2'd1, -16'sd30, -16'sd25, -16'sd12, -16'sd5, 8'd4, 8'd5, 8'd4, 4'hF, 16'sd25, 16'sd30, 16'sd25, 16'sd30, 1'b0},
        '{2'd2, 16'sd20, 16'sd40, 16'sd12, 16'sd14, 8'd6, 8'd7, 8'd7, 4'hF, 16'sd25, 16'sd28, 16'sd25, 16'sd28, 1'b0},
        '{2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0, 8'd5, 4'hC, 16'sd0, 16'sd0, 16'sd10, 16'sd12, 1'b0},
        '{2'd0, 16'sd20, 16'sd21, 16'sd15, 16'sd30, 8'd8, 8'd9, 8'd9, 4'hC, 16'sd0, 16'sd0, 16'sd10, 16'sd12, 1'b0},
        '{2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0, 8'd8, 4'hC, 16'sd0, 16'sd0, 16'sd10, 16'sd11, 1'b0},
        '{2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0, 8'd3, 4'hF, 16'sd50, 16'sd70, 16'sd40, 16'sd60, 1'b0},
        '{2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0, 8'd3, 4'hF, 16'sd50, 16'sd70, 16'sd40, 16'sd60, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, node_valid = 1'b0;
    logic [NR-1:0] ray_valid = '0, hit_we = '0, act_mask;
    logic [AW-1:0] root_addr = '0, node_child0 = '0, node_child1 = '0, fetch_addr;
    logic [NR-1:0][DW-1:0] init_near, init_far, init_hit, hit_data, cur_near, cur_far;
    logic [NR-1:0][2:0][DW-1:0] ray_org, ray_inv;
    logic [1:0] node_axis = '0;
    logic [DW-1:0] node_lo0 = '0, node_hi0 = '0, node_lo1 = '0, node_hi1 = '0;
    logic busy, done, stack_overflow;
    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    slab_step_unit #(.NR(NR), .DW(DW), .FRAC(FRAC), .AW(AW), .DEPTH(DEPTH)) i_slab_step_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ray_valid(ray_valid), .root_addr(root_addr),
        .init_near(init_near), .init_far(init_far), .init_hit(init_hit),
        .ray_org(ray_org), .ray_inv(ray_inv), .hit_we(hit_we), .hit_data(hit_data),
        .node_valid(node_valid), .node_axis(node_axis),
        .node_lo0(node_lo0), .node_hi0(node_hi0), .node_lo1(node_lo1), .node_hi1(node_hi1),
        .node_child0(node_child0), .node_child1(node_child1),
        .fetch_addr(fetch_addr), .act_mask(act_mask), .cur_near(cur_near), .cur_far(cur_far),
        .busy(busy), .done(done), .stack_overflow(stack_overflow)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_start(input logic [NR-1:0] valid);
        @(negedge clk);
        start = 1'b1; ray_valid = valid; root_addr = 8'd1;
        for (int i = 0; i < NR; i++) begin
            init_near[i] = 16'sd0; init_far[i] = 16'sd100; init_hit[i] = 16'sd1000;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_step(input logic [1:0] ax, input logic [15:0] l0, h0, l1, h1, input logic [7:0] c0, c1);
        @(negedge clk);
        node_valid = 1'b1; node_axis = ax;
        node_lo0 = l0; node_hi0 = h0; node_lo1 = l1; node_hi1 = h1;
        node_child0 = c0; node_child1 = c1;
        @(negedge clk);
        node_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            ray_org[i][0] = (i >= 2) ? 16'sd10 : 16'sd0;
            ray_org[i][1] = '0;
            ray_org[i][2] = '0;
            ray_inv[i][0] = 16'sd16;
            ray_inv[i][1] = -16'sd16;
            ray_inv[i][2] = 16'sd32;
            init_near[i] = '0; init_far[i] = '0; init_hit[i] = '0; hit_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "overflow", int'(stack_overflow), 0);
        check("R1", "mask", int'(act_mask), 0);
        rst_n = 1'b1;

        // R2 load
        do_start(4'hF);
        check("R2", "busy", int'(busy), 1);
        check("R2", "fetch_addr", int'(fetch_addr), 1);
        check("R2", "mask", int'(act_mask), 15);
        check("R2", "far0", int'($signed(cur_far[0])), 100);

        // Table walk: R3 R4 R6 R7 R8
        for (int k = 0; k < 8; k++) begin
            do_step(TBL[k].axis, TBL[k].lo0, TBL[k].hi0, TBL[k].lo1, TBL[k].hi1, TBL[k].c0, TBL[k].c1);
            check("R7/R8 table", $sformatf("addr v%0d", k), int'(fetch_addr), int'(TBL[k].eaddr));
            check("R6/R8 table", $sformatf("mask v%0d", k), int'(act_mask), int'(TBL[k].emask));
            check("R8 table", $sformatf("done v%0d", k), int'(done), int'(TBL[k].edone));
            for (int i = 0; i < NR; i++) begin
                if (TBL[k].emask[i]) begin
                    check("R3/R6 table", $sformatf("near v%0d r%0d", k, i), int'($signed(cur_near[i])),
                          int'($signed((i < 2) ? TBL[k].na : TBL[k].nb)));
                    check("R3/R6 table", $sformatf("far v%0d r%0d", k, i), int'($signed(cur_far[i])),
                          int'($signed((i < 2) ? TBL[k].fa : TBL[k].fb)));
                end
            end
        end
        check("R8", "busy after finish", int'(busy), 0);

        // R2, R11, R9, R5: ray 2 invalid, ray 1 hit below near, ray 0 hit equal to near
        do_start(4'b1011);
        @(negedge clk);
        hit_we = 4'b0011; hit_data[0] = 16'sd0; hit_data[1] = -16'sd5;
        @(negedge clk);
        hit_we = '0;
        check("R9", "addr held without node", int'(fetch_addr), 1);
        check("R9", "mask held without node", int'(act_mask), 11);
        do_step(2'd0, 16'sd20, 16'sd40, 16'sd50, 16'sd70, 8'd2, 8'd3);
        check("R5 R11", "mask after termination", int'(act_mask), 9);
        check("R5", "addr", int'(fetch_addr), 2);

        // R10 overflow with DEPTH=4
        do_start(4'hF);
        for (int k = 0; k < 5; k++) begin
            do_step(2'd0, 16'sd0, 16'sd10, 16'sd0, 16'sd10, 8'(20 + k), 8'(10 + k));
            if (k == 3) check("R10", "no overflow at full", int'(stack_overflow), 0);
        end
        check("R10", "overflow set", int'(stack_overflow), 1);
        check("R10", "descent still taken", int'(fetch_addr), 24);
        for (int k = 0; k < 4; k++) begin
            do_step(2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0);
            check("R10", $sformatf("pop %0d", k), int'(fetch_addr), 13 - k);
            check("R10", "still walking", int'(busy), 1);
        end
        do_step(2'd0, 16'sd200, 16'sd210, 16'sd300, 16'sd310, 8'd0, 8'd0);
        check("R10", "done after dropped entry", int'(done), 1);
        check("R10", "overflow sticky", int'(stack_overflow), 1);

        // R12 restart from done
        do_start(4'hF);
        check("R12", "overflow cleared", int'(stack_overflow), 0);
        check("R12", "busy", int'(busy), 1);
        check("R12", "done", int'(done), 0);
        check("R12", "addr", int'(fetch_addr), 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule